// File: doc/BRIEF.md
# Pipelined Virtual-Channel Router

This block is a five-port on-chip network router with several virtual channels (VCs) on each input. Each arriving flit is written into a FIFO owned by the input VC named in the flit. The first stage works on a head flit at the front of an idle FIFO. It computes the output port from the head's destination coordinates, using X-first then Y routing. In the same cycle it claims a free VC on that port. The result is held in per-input-VC route, output-VC and active registers.

The second stage forms switch requests from those registers only. A request needs the claimed output VC to have a downstream credit. Round-robin arbiters decide, first within each input and then at each output. A winner dequeues its front flit into a data register at the crossbar input, and the flit's VC field is replaced with the claimed output VC. The third stage sends that register through a crossbar, which is steered by select registers loaded at the winning edge.

Credits are handled on both sides. A pulse goes back upstream for every dequeued flit. A counter for each output VC spends a credit per flit sent and recovers one per downstream return. A tail flit frees the output VC and returns its input VC to idle.

Top module: `vcr_router`

## Requirements
- R1: A head flit carries destination X in data bits [1:0] and Y in bits [3:2]. With the router at (1,1), it leaves on port 1 when X>1, port 2 when X<1, port 3 when X=1 and Y>1, port 4 when X=1 and Y<1, and port 0 when both match. X is resolved before Y.
- R2: An uncontended flit sampled at clock edge k is valid on its output after edge k+2. Flits of the same packet sampled on consecutive edges leave on consecutive cycles.
- R3: Each dequeued flit produces one cycle of `in_credit_ret` on bit port*NUM_VC+vc, in the cycle the flit is first valid at the output. An input FIFO is never written while full.
- R4: The output VC field carries the output VC allocated to the packet, which is the lowest-numbered free VC of that port. The input VC number has no effect on it.
- R5: An output VC stays locked from allocation until its packet's tail is sent. Two packets holding the same output port at once have different output VCs, and each packet's flits keep their packet's VC.
- R6: A flit is sent only while its output VC's counter is non-zero. The counter starts at CREDITS, loses one per flit sent and gains one per `out_credit_in` pulse. Traffic stalls at zero and resumes on a returned credit.
- R7: Each cycle grants at most one flit per input port and one per output port. Packets contending for one output alternate under round-robin priority.
- R8: Flits of a packet leave in arrival order, with the tail last.
- R9: After reset no output is valid, no credit is returned upstream, and every output VC is free with CREDITS credits.
- Type field encoding: bit 0 = head, bit 1 = tail. A single-flit packet uses 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Flit present, one bit per input port |
| in_vc | input | 5*VCW | Input VC of each flit |
| in_type | input | 10 | Type per port (bit 0 head, bit 1 tail) |
| in_data | input | 5*DATA_W | Flit payload per port |
| in_credit_ret | output | 5*NUM_VC | Credit back to the upstream router, per input VC |
| out_valid | output | 5 | Flit leaving, one bit per output port |
| out_vc | output | 5*VCW | Rewritten output VC per port |
| out_type | output | 10 | Type per output port |
| out_data | output | 5*DATA_W | Payload per output port |
| out_credit_in | input | 5*NUM_VC | Credit returned from downstream, per output VC |

## Verification
The embedded properties check several rules on every cycle:
- credit counters stay within their bounds, and no flit is charged to a VC with zero credit or to an unlocked VC;
- a VC is allocated only while free;
- no input wins two outputs at once;
- no FIFO is written while full;
- every output request becomes a valid output one cycle later.

Other behaviour needs the bench scenarios. These cover the routing for each destination direction, the exact three-edge latency, the rewritten VC numbers and the lowest-free choice. They also cover in-order delivery, the alternation of two packets sharing a port, and the stall and resume of a packet on downstream credits.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int NP      = 5;  // local, east, west, north, south
  localparam int PW      = 3;
  localparam int P_LOCAL = 0;
  localparam int P_EAST  = 1;
  localparam int P_WEST  = 2;
  localparam int P_NORTH = 3;
  localparam int P_SOUTH = 4;
  localparam int FT_HEAD = 0;
  localparam int FT_TAIL = 1;
endpackage

// File: rtl/vcr_rr_arb.sv
module vcr_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [IW-1:0] win
);
  logic [IW-1:0] ptr;
  logic          hit;

  always_comb begin
    win = '0;
    hit = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!hit && req[(int'(ptr) + k) % N]) begin
        win = IW'((int'(ptr) + k) % N);
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv && |req) ptr <= (int'(win) == N - 1) ? '0 : win + 1'b1;
  end

  // R7: the rotating pointer never leaves the requester range
  p_ptr_range_r7: assert property (@(posedge clk) disable iff (rst) int'(ptr) < N);
endmodule

// File: rtl/vcr_vc_fifo.sv
module vcr_vc_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr) wptr <= (int'(wptr) == DEPTH - 1) ? '0 : wptr + 1'b1;
      if (rd) rptr <= (int'(rptr) == DEPTH - 1) ? '0 : rptr + 1'b1;
      count <= count + (AW+1)'(wr) - (AW+1)'(rd);
    end
  end

  assign rdata = mem[rptr];
  assign empty = (count == '0);

  // R3: upstream credit discipline keeps the buffer from overflowing
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    wr |-> (int'(count) < DEPTH) || rd);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
    rd |-> !empty);
endmodule

// File: rtl/vcr_router.sv
module vcr_router import vcr_pkg::*; #(
  parameter int NUM_VC    = 2,
  parameter int BUF_DEPTH = 4,
  parameter int DATA_W    = 16,
  parameter int COORD_W   = 2,
  parameter int CREDITS   = 4,
  parameter int MY_X      = 1,
  parameter int MY_Y      = 1,
  localparam int VCW  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int NIVC = NP * NUM_VC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NP-1:0]        in_valid,
  input  logic [NP*VCW-1:0]    in_vc,
  input  logic [NP*2-1:0]      in_type,
  input  logic [NP*DATA_W-1:0] in_data,
  output logic [NIVC-1:0]      in_credit_ret,
  output logic [NP-1:0]        out_valid,
  output logic [NP*VCW-1:0]    out_vc,
  output logic [NP*2-1:0]      out_type,
  output logic [NP*DATA_W-1:0] out_data,
  input  logic [NIVC-1:0]      out_credit_in
);
  localparam int FW  = DATA_W + 2;
  localparam int XW  = FW + VCW;
  localparam int CW  = $clog2(CREDITS + 1);
  localparam int IVW = $clog2(NIVC);

  function automatic logic [PW-1:0] xy_route(input logic [2*COORD_W-1:0] d);
    logic [COORD_W-1:0] dx, dy;
    dx = d[COORD_W-1:0];
    dy = d[2*COORD_W-1:COORD_W];
    if (dx > COORD_W'(MY_X))      return PW'(P_EAST);
    else if (dx < COORD_W'(MY_X)) return PW'(P_WEST);
    else if (dy > COORD_W'(MY_Y)) return PW'(P_NORTH);
    else if (dy < COORD_W'(MY_Y)) return PW'(P_SOUTH);
    return PW'(P_LOCAL);
  endfunction

  logic [FW-1:0]     front   [NIVC];
  logic [NIVC-1:0]   vc_empty, deq, vc_act, va_win;
  logic [PW-1:0]     rt_comb [NIVC];
  logic [PW-1:0]     rt_reg  [NIVC];
  logic [VCW-1:0]    ovc_reg [NIVC];
  logic [NUM_VC-1:0] ovc_busy [NP];
  logic [NUM_VC-1:0] va_set   [NP];
  logic [NUM_VC-1:0] busy_clr [NP];
  logic [NUM_VC-1:0] cdec     [NP];
  logic [CW-1:0]     cred     [NP][NUM_VC];
  logic [NIVC-1:0]   va_req   [NP];
  logic [IVW-1:0]    va_idx   [NP];
  logic [VCW-1:0]    va_pick  [NP];
  logic [NUM_VC-1:0] sa_ireq  [NP];
  logic [VCW-1:0]    vsel     [NP];
  logic [PW-1:0]     ip_out   [NP];
  logic [NP-1:0]     ip_has, sa_win_in, xsel_v;
  logic [NP-1:0]     sa_oreq  [NP];
  logic [NP-1:0]     sa_ogn   [NP];
  logic [NP-1:0]     col      [NP];
  logic [PW-1:0]     oidx     [NP];
  logic [PW-1:0]     xsel     [NP];
  logic [XW-1:0]     xdata    [NP];

  // Input VC buffers and the combinational route of each front flit
  for (genvar p = 0; p < NP; p++) begin : g_port
    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      localparam int I = p * NUM_VC + v;
      vcr_vc_fifo #(.W(FW), .DEPTH(BUF_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .wr    (in_valid[p] && (in_vc[p*VCW +: VCW] == VCW'(v))),
        .wdata ({in_type[p*2 +: 2], in_data[p*DATA_W +: DATA_W]}),
        .rd    (deq[I]),
        .rdata (front[I]),
        .empty (vc_empty[I])
      );
      assign rt_comb[I] = xy_route(front[I][2*COORD_W-1:0]);
    end
    vcr_rr_arb #(.N(NUM_VC)) u_sa_in (
      .clk(clk), .rst(rst), .req(sa_ireq[p]), .adv(sa_win_in[p]), .win(vsel[p]));
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    vcr_rr_arb #(.N(NIVC)) u_va (
      .clk(clk), .rst(rst), .req(va_req[o]), .adv(1'b1), .win(va_idx[o]));
    vcr_rr_arb #(.N(NP)) u_sa_out (
      .clk(clk), .rst(rst), .req(sa_oreq[o]), .adv(1'b1), .win(oidx[o]));
  end

  // Stage 1: route bypasses straight into VC allocation
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      va_pick[o] = '0;
      for (int w = NUM_VC - 1; w >= 0; w--)
        if (!ovc_busy[o][w]) va_pick[o] = VCW'(w);
      for (int i = 0; i < NIVC; i++)
        va_req[o][i] = !vc_act[i] && !vc_empty[i] && front[i][DATA_W+FT_HEAD]
                       && (rt_comb[i] == PW'(o)) && !(&ovc_busy[o]);
    end
  end

  always_comb begin
    va_win = '0;
    for (int o = 0; o < NP; o++) begin
      va_set[o] = '0;
      if (|va_req[o]) va_set[o][va_pick[o]] = 1'b1;
      for (int i = 0; i < NIVC; i++)
        if (|va_req[o] && va_idx[o] == IVW'(i)) va_win[i] = 1'b1;
    end
  end

  // Stage 2: switch requests from registered allocation state only
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      for (int v = 0; v < NUM_VC; v++)
        sa_ireq[p][v] = vc_act[p*NUM_VC+v] && !vc_empty[p*NUM_VC+v]
                        && (cred[rt_reg[p*NUM_VC+v]][ovc_reg[p*NUM_VC+v]] != '0);
      ip_has[p] = |sa_ireq[p];
      ip_out[p] = rt_reg[p*NUM_VC + int'(vsel[p])];
    end
    for (int o = 0; o < NP; o++)
      for (int p = 0; p < NP; p++)
        sa_oreq[o][p] = ip_has[p] && (ip_out[p] == PW'(o));
  end

  always_comb begin
    sa_win_in = '0;
    for (int o = 0; o < NP; o++) begin
      cdec[o] = '0;
      busy_clr[o] = '0;
      for (int p = 0; p < NP; p++) begin
        sa_ogn[o][p] = |sa_oreq[o] && (oidx[o] == PW'(p));
        col[p][o]    = sa_ogn[o][p];
        if (sa_ogn[o][p]) sa_win_in[p] = 1'b1;
      end
    end
    for (int i = 0; i < NIVC; i++) begin
      deq[i] = sa_win_in[i/NUM_VC] && (vsel[i/NUM_VC] == VCW'(i % NUM_VC));
      if (deq[i]) begin
        cdec[rt_reg[i]][ovc_reg[i]] = 1'b1;
        if (front[i][DATA_W+FT_TAIL]) busy_clr[rt_reg[i]][ovc_reg[i]] = 1'b1;
      end
    end
  end

  // Control state with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      vc_act        <= '0;
      xsel_v        <= '0;
      in_credit_ret <= '0;
      for (int o = 0; o < NP; o++) begin
        ovc_busy[o] <= '0;
        for (int w = 0; w < NUM_VC; w++) cred[o][w] <= CW'(CREDITS);
      end
    end else begin
      in_credit_ret <= deq;
      for (int o = 0; o < NP; o++) begin
        xsel_v[o]   <= |sa_oreq[o];
        ovc_busy[o] <= (ovc_busy[o] | va_set[o]) & ~busy_clr[o];
        for (int w = 0; w < NUM_VC; w++)
          cred[o][w] <= cred[o][w] + CW'(out_credit_in[o*NUM_VC+w]) - CW'(cdec[o][w]);
      end
      for (int i = 0; i < NIVC; i++) begin
        if (va_win[i]) vc_act[i] <= 1'b1;
        else if (deq[i] && front[i][DATA_W+FT_TAIL]) vc_act[i] <= 1'b0;
      end
    end
  end

  // Data-path registers: allocation results, crossbar input and selects
  always_ff @(posedge clk) begin
    for (int i = 0; i < NIVC; i++) begin
      if (va_win[i]) begin
        rt_reg[i]  <= rt_comb[i];
        ovc_reg[i] <= va_pick[rt_comb[i]];
      end
    end
    for (int p = 0; p < NP; p++) begin
      if (sa_win_in[p])
        xdata[p] <= {front[p*NUM_VC+int'(vsel[p])][DATA_W +: 2],
                     ovc_reg[p*NUM_VC+int'(vsel[p])],
                     front[p*NUM_VC+int'(vsel[p])][DATA_W-1:0]};
    end
    for (int o = 0; o < NP; o++) xsel[o] <= oidx[o];
  end

  // Stage 3: crossbar traversal
  always_comb begin
    out_valid = xsel_v;
    for (int o = 0; o < NP; o++)
      {out_type[o*2 +: 2], out_vc[o*VCW +: VCW], out_data[o*DATA_W +: DATA_W]} = xdata[xsel[o]];
  end

  for (genvar o = 0; o < NP; o++) begin : g_chk_out
    // R2: a switch request at an output becomes a valid flit on the next cycle
    p_sa_to_out_r2: assert property (@(posedge clk) disable iff (rst)
      |sa_oreq[o] |=> out_valid[o]);
    for (genvar w = 0; w < NUM_VC; w++) begin : g_chk_vc
      p_credit_max_r6: assert property (@(posedge clk) disable iff (rst)
        cred[o][w] <= CW'(CREDITS));
      p_send_needs_credit_r6: assert property (@(posedge clk) disable iff (rst)
        cdec[o][w] |-> cred[o][w] != '0);
      p_alloc_free_vc_r5: assert property (@(posedge clk) disable iff (rst)
        va_set[o][w] |-> !ovc_busy[o][w]);
      p_send_locked_r5: assert property (@(posedge clk) disable iff (rst)
        cdec[o][w] |-> ovc_busy[o][w]);
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_chk_in
    p_one_out_per_input_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col[p]));
  end
endmodule

// File: tb/test_vcr_router.sv
module test_vcr_router;
  localparam int NP = 5;
  localparam int NV = 2;
  localparam int DW = 16;
  localparam int NI = NP * NV;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] in_valid = '0;
  logic [NP-1:0] in_vc = '0;
  logic [NP*2-1:0]  in_type = '0;
  logic [NP*DW-1:0] in_data = '0;
  logic [NI-1:0] in_credit_ret;
  logic [NP-1:0] out_valid;
  logic [NP-1:0] out_vc;
  logic [NP*2-1:0]  out_type;
  logic [NP*DW-1:0] out_data;
  logic [NI-1:0] out_credit_in = '0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  vcr_router i_vcr_router (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vc(in_vc), .in_type(in_type),
    .in_data(in_data), .in_credit_ret(in_credit_ret), .out_valid(out_valid),
    .out_vc(out_vc), .out_type(out_type), .out_data(out_data),
    .out_credit_in(out_credit_in));

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int p, input int v, input logic [1:0] t, input logic [15:0] d);
    in_valid[p] = 1'b1;
    in_vc[p] = v[0];
    in_type[p*2 +: 2] = t;
    in_data[p*DW +: DW] = d;
  endtask

  // {source port, dest x, dest y, expected output port}, router at (1,1)
  localparam logic [9:0] VEC [8] = '{
    {3'd0, 2'd1, 2'd1, 3'd0},
    {3'd0, 2'd3, 2'd0, 3'd1},
    {3'd0, 2'd0, 2'd3, 3'd2},
    {3'd1, 2'd1, 2'd2, 3'd3},
    {3'd2, 2'd1, 2'd0, 3'd4},
    {3'd3, 2'd2, 2'd1, 3'd1},
    {3'd4, 2'd0, 2'd1, 3'd2},
    {3'd1, 2'd1, 2'd3, 3'd3}
  };

  initial begin
    int sp, ep, na, nb, ta0, tat, tb0, tbt, crd, cnt;
    bit oka, okb;
    logic va, vb;
    logic [15:0] d;
    logic [15:0] exp_d;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: quiet after reset
    check(out_valid == '0, "R9 out_valid after reset", 32'(out_valid), 0);
    check(in_credit_ret == '0, "R9 credit return after reset", 32'(in_credit_ret), 0);

    // Vector table: single-flit packets, one per routing case (R1, R2, R3, R4)
    for (int k = 0; k < 8; k++) begin
      sp = int'(VEC[k][9:7]);
      ep = int'(VEC[k][2:0]);
      exp_d = {4'h5, 4'(k), 4'h0, VEC[k][4:3], VEC[k][6:5]};
      put(sp, 0, 2'b11, exp_d);
      @(negedge clk); in_valid = '0;
      @(negedge clk);
      @(negedge clk);
      check(out_valid == 5'(1 << ep), "R1 route port", 32'(out_valid), 32'(1 << ep));
      check(out_data[ep*DW +: DW] == exp_d, "R2 data at third edge", 32'(out_data[ep*DW +: DW]), 32'(exp_d));
      check(out_vc[ep] == 1'b0, "R4 output vc", 32'(out_vc[ep]), 0);
      check(in_credit_ret == 10'(1 << (sp*NV)), "R3 credit return", 32'(in_credit_ret), 32'(1 << (sp*NV)));
      out_credit_in[ep*NV] = 1'b1;
      @(negedge clk); out_credit_in = '0;
    end

    // R2/R8/R4: back-to-back three-flit packet on input vc 1 toward east
    put(0, 1, 2'b01, 16'hA006);
    @(negedge clk); put(0, 1, 2'b00, 16'hA106);
    @(negedge clk); put(0, 1, 2'b10, 16'hA206);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); in_valid = '0;
      exp_d = {4'hA, 4'(k), 8'h06};
      check(out_valid == 5'b00010, "R2 back-to-back valid", 32'(out_valid), 2);
      check(out_data[DW +: DW] == exp_d, "R8 flit order", 32'(out_data[DW +: DW]), 32'(exp_d));
      check(out_type[2 +: 2] == ((k == 0) ? 2'b01 : (k == 2) ? 2'b10 : 2'b00), "R8 flit type",
            32'(out_type[2 +: 2]), 32'(k));
      check(out_vc[1] == 1'b0, "R4 lowest free vc from input vc 1", 32'(out_vc[1]), 0);
      check(in_credit_ret == 10'b0000000010, "R3 credit per flit", 32'(in_credit_ret), 2);
    end
    for (int k = 0; k < 3; k++) begin
      out_credit_in[2] = 1'b1; @(negedge clk);
    end
    out_credit_in = '0;

    // R5/R7/R8: two packets from west and north inputs both to east
    na = 0; nb = 0; ta0 = 0; tat = 0; tb0 = 0; tbt = 0; crd = 0;
    oka = 1; okb = 1; va = 0; vb = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      in_valid = '0;
      out_credit_in = '0;
      if (out_valid[1]) begin
        d = out_data[DW +: DW];
        out_credit_in[2 + int'(out_vc[1])] = 1'b1;
        if (d[15:12] == 4'hB) begin
          if (int'(d[11:8]) != na) oka = 0;
          if (na == 2 && out_type[2 +: 2] != 2'b10) oka = 0;
          if (na == 0) begin va = out_vc[1]; ta0 = k; end
          else if (out_vc[1] != va) oka = 0;
          if (na == 2) tat = k;
          na++;
        end else begin
          if (int'(d[11:8]) != nb) okb = 0;
          if (nb == 2 && out_type[2 +: 2] != 2'b10) okb = 0;
          if (nb == 0) begin vb = out_vc[1]; tb0 = k; end
          else if (out_vc[1] != vb) okb = 0;
          if (nb == 2) tbt = k;
          nb++;
        end
      end
      crd += int'(in_credit_ret[5]) + int'(in_credit_ret[6]);
      if (k < 3) begin
        put(2, 1, (k == 0) ? 2'b01 : (k == 2) ? 2'b10 : 2'b00, {4'hB, 4'(k), 8'h07});
        put(3, 0, (k == 0) ? 2'b01 : (k == 2) ? 2'b10 : 2'b00, {4'hC, 4'(k), 8'h0A});
      end
    end
    @(negedge clk); out_credit_in = '0;
    check(na == 3 && oka, "R8 packet from west in order", 32'(na), 3);
    check(nb == 3 && okb, "R8 packet from north in order", 32'(nb), 3);
    check(va != vb, "R5 distinct output vcs", 32'(va), 32'(!vb));
    check(ta0 < tbt && tb0 < tat, "R7 round-robin interleave", 32'(tb0), 32'(tat));
    check(crd == 6, "R3 credit returns under contention", 32'(crd), 6);

    // R6/R9: five-flit packet to south with no downstream credit returned
    cnt = 0; crd = 0; d = '0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      in_valid = '0;
      if (out_valid[4]) begin cnt++; d = out_data[4*DW +: DW]; end
      crd += int'(in_credit_ret[2]);
      if (k < 5) put(1, 0, (k == 0) ? 2'b01 : (k == 4) ? 2'b10 : 2'b00, {4'hD, 4'(k), 8'h01});
    end
    check(cnt == 4, "R6 R9 sends limited to initial credits", 32'(cnt), 4);
    check(d[11:8] == 4'd3, "R8 last sent before stall", 32'(d[11:8]), 3);
    check(crd == 4, "R3 no credit return while stalled", 32'(crd), 4);
    out_credit_in[8] = 1'b1;
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      out_credit_in = '0;
      if (out_valid[4]) begin
        cnt++;
        check(out_data[4*DW +: DW] == 16'hD401 && out_type[8 +: 2] == 2'b10,
              "R6 tail resumes after credit", 32'(out_data[4*DW +: DW]), 32'hD401);
      end
    end
    check(cnt == 1, "R6 exactly one flit per returned credit", 32'(cnt), 1);
    for (int k = 0; k < 4; k++) begin
      out_credit_in[8] = 1'b1; @(negedge clk);
    end
    out_credit_in = '0;
    @(negedge clk);
    check(out_valid == '0, "R5 idle after tails", 32'(out_valid), 0);

    summary();
    $finish;
  end
endmodule